// File: doc/BRIEF.md
# Link Breakpoint Monitor

The block sits beside one valid/accept handshake link of an on-chip interconnect and compares every word that crosses the link against a breakpoint value held in a configuration register. The word under test is the link's data and control signals joined into one W-bit vector. When an accepted transfer carries exactly the programmed value and the monitor is armed, the block sets a sticky triggered flag and sends a one-cycle event pulse. That pulse goes out to the event distribution network, which uses it to stop traffic across the chip.

Software arms the monitor with one parallel write of the W+2-bit register: the breakpoint value, the enable bit and the triggered bit. It then polls the register through the parallel read port until the triggered flag comes up. Any new write clears the flag and rearms the monitor. Only the handshake level is observed; the block decodes no protocol above it.

Top module: `link_bp_monitor`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `cfg_rdata` reads all zero and `evt_pulse` is low.
- R2: A write (`cfg_wr` high at a rising edge) loads `cfg_wdata[W-1:0]` as the breakpoint value and `cfg_wdata[W]` as the enable bit. From that edge on, `cfg_rdata` returns the value in bits W-1:0, enable in bit W and the triggered flag in bit W+1.
- R3: If `lnk_valid` and `lnk_accept` are both high at rising edge n, the monitor is enabled, and the word equals the breakpoint value, the triggered flag reads 1 from edge n+1. `evt_pulse` is also high for exactly the cycle between edges n+1 and n+2.
- R4: A cycle where `lnk_valid` or `lnk_accept` is low is never compared, whatever the link carries.
- R5: Once triggered, the flag stays set and further matching transfers produce no new event pulse until the next write.
- R6: Every write clears the triggered flag and suppresses the event. A write at edge n+1 overrides a match captured at edge n.
- R7: With the enable bit at 0, no transfer sets the flag or pulses the event.
- R8: The compared word is `{lnk_ctrl, lnk_data}`, with the control bits above the data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lnk_valid | input | 1 | Monitored link valid |
| lnk_accept | input | 1 | Monitored link accept |
| lnk_data | input | DATA_W | Monitored link data |
| lnk_ctrl | input | CTRL_W | Monitored link control signals |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | DATA_W+CTRL_W+2 | Register write value |
| cfg_rdata | output | DATA_W+CTRL_W+2 | Register read value (triggered, enable, breakpoint) |
| evt_pulse | output | 1 | One-cycle event toward the event network |

## Verification
The bench aims for a matching word shown with only valid or only accept high. A design that compared without the full handshake would trigger there. It repeats a match after the flag is set, which exposes a design that pulses on every hit. It also puts a write right behind a captured match: a design with the wrong priority would leave the flag set. The breakpoint is placed where data and control bits differ, so a swapped concatenation misses the match, and random traffic over a small value set checks the pulse timing against a cycle model.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  typedef struct packed {
    logic trig;
    logic en;
  } lbm_flags_t;
endpackage

// File: rtl/lbm_sampler.sv
module lbm_sampler #(
  parameter int DATA_W = 16,
  parameter int CTRL_W = 4,
  localparam int W = DATA_W + CTRL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              accept,
  input  logic [DATA_W-1:0] data,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              hs_q,
  output logic [W-1:0]      word_q
);
  // One register stage: a handshake and its word are captured together.
  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q   <= 1'b0;
      word_q <= '0;
    end else begin
      hs_q   <= valid & accept;
      word_q <= {ctrl, data};   // R8 control above data
    end
  end
endmodule

// File: rtl/lbm_compare.sv
module lbm_compare #(
  parameter int W = 20
) (
  input  logic         en,
  input  logic         hs_q,
  input  logic [W-1:0] word_q,
  input  logic [W-1:0] cond,
  output logic         hit
);
  logic [W-1:0] eq_bit;
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      assign eq_bit[gi] = ~(word_q[gi] ^ cond[gi]);
    end
  endgenerate

  always_comb hit = en & hs_q & (&eq_bit);
endmodule

// File: rtl/lbm_status.sv
module lbm_status #(
  parameter int W = 20,
  localparam int RW = W + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [RW-1:0] wdata,
  input  logic          hit,
  output logic [W-1:0]  cond,
  output logic          en,
  output logic [RW-1:0] rdata,
  output logic          evt
);
  import lbm_pkg::*;
  lbm_flags_t flg;
  logic [W-1:0] cond_q;
  logic         evt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= '0;
      flg    <= '0;
      evt_q  <= 1'b0;
    end else if (wr) begin
      cond_q   <= wdata[W-1:0];
      flg.en   <= wdata[W];
      flg.trig <= 1'b0;
      evt_q    <= 1'b0;
    end else begin
      evt_q <= hit & ~flg.trig;
      if (hit) flg.trig <= 1'b1;
    end
  end

  assign cond  = cond_q;
  assign en    = flg.en;
  assign rdata = {flg.trig, flg.en, cond_q};
  assign evt   = evt_q;

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst) evt_q |=> !evt_q); // R5
  AST_EVT_HAS_TRIG: assert property (@(posedge clk) disable iff (rst) evt_q |-> flg.trig); // R3
  AST_TRIG_STICKY: assert property (@(posedge clk) disable iff (rst) (flg.trig && !wr) |=> flg.trig); // R5
  AST_WR_CLEARS: assert property (@(posedge clk) disable iff (rst) wr |=> (!flg.trig && !evt_q)); // R6
  AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (rst) (!flg.en && !wr) |=> !evt_q); // R7
endmodule

// File: rtl/link_bp_monitor.sv
module link_bp_monitor #(
  parameter int DATA_W = 16,
  parameter int CTRL_W = 4,
  localparam int W  = DATA_W + CTRL_W,
  localparam int RW = W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lnk_valid,
  input  logic              lnk_accept,
  input  logic [DATA_W-1:0] lnk_data,
  input  logic [CTRL_W-1:0] lnk_ctrl,
  input  logic              cfg_wr,
  input  logic [RW-1:0]     cfg_wdata,
  output logic [RW-1:0]     cfg_rdata,
  output logic              evt_pulse
);
  logic         hs_q;
  logic [W-1:0] word_q;
  logic [W-1:0] cond;
  logic         en;
  logic         hit;

  lbm_sampler #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_smp (
    .clk(clk), .rst(rst), .valid(lnk_valid), .accept(lnk_accept),
    .data(lnk_data), .ctrl(lnk_ctrl), .hs_q(hs_q), .word_q(word_q)
  );

  lbm_compare #(.W(W)) u_cmp (
    .en(en), .hs_q(hs_q), .word_q(word_q), .cond(cond), .hit(hit)
  );

  lbm_status #(.W(W)) u_sts (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(cfg_wdata), .hit(hit),
    .cond(cond), .en(en), .rdata(cfg_rdata), .evt(evt_pulse)
  );

  AST_EVT_NEEDS_HS: assert property (@(posedge clk) disable iff (rst)
    (evt_pulse && !$past(rst)) |-> $past(lnk_valid && lnk_accept, 2)); // R4
  AST_HIT_NEEDS_HS: assert property (@(posedge clk) disable iff (rst) hit |-> hs_q); // R4
endmodule

// File: tb/link_bp_monitor_test.sv
module link_bp_monitor_test;
  localparam int DATA_W = 16;
  localparam int CTRL_W = 4;
  localparam int W  = DATA_W + CTRL_W;
  localparam int RW = W + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lnk_valid = 0, lnk_accept = 0, cfg_wr = 0;
  logic [DATA_W-1:0] lnk_data = '0;
  logic [CTRL_W-1:0] lnk_ctrl = '0;
  logic [RW-1:0] cfg_wdata = '0;
  logic [RW-1:0] cfg_rdata;
  logic evt_pulse;

  int vectors = 0;
  int errors  = 0;

  // model state
  logic [W-1:0] m_cond = '0;
  logic m_en = 0, m_trig = 0, m_evt = 0, m_hs = 0;
  logic [W-1:0] m_word = '0;

  always #2 clk = ~clk;   // 250 MHz

  link_bp_monitor #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) uut (
    .clk(clk), .rst(rst), .lnk_valid(lnk_valid), .lnk_accept(lnk_accept),
    .lnk_data(lnk_data), .lnk_ctrl(lnk_ctrl), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .evt_pulse(evt_pulse)
  );

  function automatic logic [RW-1:0] exp_rdata();
    return {m_trig, m_en, m_cond};
  endfunction

  function automatic logic [RW-1:0] cfg_word(logic en, logic [W-1:0] c);
    return {1'b0, en, c};
  endfunction

  // advance model by one edge using inputs held across it
  task automatic model_step();
    if (rst) begin
      m_cond = '0; m_en = 0; m_trig = 0; m_evt = 0; m_hs = 0; m_word = '0;
    end else begin
      logic hit;
      hit = m_en && m_hs && (m_word == m_cond);
      if (cfg_wr) begin
        m_cond = cfg_wdata[W-1:0]; m_en = cfg_wdata[W]; m_trig = 0; m_evt = 0;
      end else begin
        m_evt = hit && !m_trig;
        if (hit) m_trig = 1;
      end
      m_hs   = lnk_valid && lnk_accept;
      m_word = {lnk_ctrl, lnk_data};
    end
  endtask

  task automatic chk(string req, logic [RW-1:0] act, logic [RW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply inputs, pass one edge, compare against model
  task automatic tick(logic v, logic a, logic [CTRL_W-1:0] c, logic [DATA_W-1:0] d,
                      logic wr, logic [RW-1:0] wd, string req);
    lnk_valid = v; lnk_accept = a; lnk_ctrl = c; lnk_data = d;
    cfg_wr = wr; cfg_wdata = wd;
    @(negedge clk);
    model_step();
    chk({req, " evt"}, {{(RW-1){1'b0}}, evt_pulse}, {{(RW-1){1'b0}}, m_evt});
    chk({req, " rdata"}, cfg_rdata, exp_rdata());
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) tick(0, 0, '0, '0, 0, '0, req);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] bp;
    void'($urandom(32'd4242));
    @(negedge clk);
    model_step();
    chk("R1 reset rdata", cfg_rdata, '0);
    chk("R1 reset evt", {{(RW-1){1'b0}}, evt_pulse}, '0);
    repeat (2) begin @(negedge clk); model_step(); end
    rst = 0;
    idle(1, "R1");
    chk("R1 after reset", cfg_rdata, '0);

    // R2 write and readback, breakpoint with ctrl=5 data=378
    bp = {4'h5, 16'd378};
    tick(0, 0, '0, '0, 1, cfg_word(1, bp), "R2");
    chk("R2 readback", cfg_rdata, {1'b0, 1'b1, bp});

    // R4 partial handshakes carrying the value
    tick(1, 0, 4'h5, 16'd378, 0, '0, "R4");
    tick(0, 1, 4'h5, 16'd378, 0, '0, "R4");
    idle(2, "R4");
    chk("R4 no trigger", cfg_rdata[RW-1], 1'b0);

    // R8 swapped order must not match
    tick(1, 1, 4'h0, {12'h0, 4'h5}, 0, '0, "R8");
    tick(1, 1, 4'h0, 16'd378, 0, '0, "R8");
    idle(2, "R8");
    chk("R8 wrong word no trigger", cfg_rdata[RW-1], 1'b0);

    // R3 match timing
    tick(1, 1, 4'h5, 16'd378, 0, '0, "R3");
    tick(0, 0, '0, '0, 0, '0, "R3");
    chk("R3 evt high", {{(RW-1){1'b0}}, evt_pulse}, 1);
    chk("R3 trig set", cfg_rdata[RW-1], 1'b1);
    tick(0, 0, '0, '0, 0, '0, "R3");
    chk("R3 evt one cycle", {{(RW-1){1'b0}}, evt_pulse}, 0);

    // R5 repeat match no pulse
    tick(1, 1, 4'h5, 16'd378, 0, '0, "R5");
    tick(0, 0, '0, '0, 0, '0, "R5");
    chk("R5 no second pulse", {{(RW-1){1'b0}}, evt_pulse}, 0);
    chk("R5 trig sticky", cfg_rdata[RW-1], 1'b1);

    // R6 write clears; write right after a captured match wins
    tick(0, 0, '0, '0, 1, cfg_word(1, bp), "R6");
    chk("R6 write clears trig", cfg_rdata[RW-1], 1'b0);
    tick(1, 1, 4'h5, 16'd378, 0, '0, "R6");
    tick(0, 0, '0, '0, 1, cfg_word(1, bp), "R6");
    chk("R6 write beats match evt", {{(RW-1){1'b0}}, evt_pulse}, 0);
    chk("R6 write beats match trig", cfg_rdata[RW-1], 1'b0);

    // R7 disabled
    tick(0, 0, '0, '0, 1, cfg_word(0, bp), "R7");
    tick(1, 1, 4'h5, 16'd378, 0, '0, "R7");
    idle(2, "R7");
    chk("R7 disabled no trig", cfg_rdata[RW-1], 1'b0);

    // random traffic against model
    for (int i = 0; i < 4000; i++) begin
      logic wr;
      logic [RW-1:0] wd;
      logic [CTRL_W-1:0] c;
      logic [DATA_W-1:0] d;
      wr = ($urandom % 40) == 0;
      wd = cfg_word(($urandom % 4) != 0, {CTRL_W'($urandom % 2), DATA_W'(($urandom % 3) + 377)});
      c  = CTRL_W'($urandom % 2);
      d  = DATA_W'(($urandom % 3) + 377);
      tick(($urandom % 3) != 0, ($urandom % 3) != 0, c, d, wr, wd, "R3 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule